// File: doc/BRIEF.md
# Nibble-Wide Printer-Port Register Access Unit

This unit sits on the device side of a printer-style parallel link and gives a host access to a small controller register file and a byte-wide packet buffer. The host drives eight data lines, plus one control line that allows the interrupt output. It reads back five status lines. Every byte crosses the link as two 4-bit nibbles. The top three bits of each data byte give its phase: end command, latch a write address, latch a read address, or carry data. Bit 4 picks the high or low half of the selected register.

The device samples the data lines once per clock. It acts only when the sampled byte differs from the one before it, so a host that repeats bytes to give slow ports time to settle gets the same result as one that sends each byte once. A read puts the selected nibble on status lines 6:3 and the gated interrupt on line 7. Register offset 14 is the buffer window. Writes to it assemble bytes low nibble first into the buffer. Reads from it step through the buffer one byte at a time.

Top module: `nibble_port_regs`

## Requirements
- R1: After reset every register and buffer byte is zero, the interrupt output is low, the status nibble is zero and both enable outputs are low.
- R2: A byte with bits 7:5 = 010 latches the offset in bits 3:0 and enters write mode, unless write mode is already active; in that case such bytes only preview data and are ignored. In write mode, a byte with bits 7:5 = 000 stores bits 3:0 into the half chosen by its bit 4 (1 = high), but only when it follows a non-data byte or its bit 4 differs from the previous byte's bit 4.
- R3: A byte equal to the previous sampled byte has no effect, and a data byte that keeps the previous bit 4 commits nothing.
- R4: A byte with bits 7:5 = 110 latches an offset and a half (bit 4). On the next cycle status lines 6:3 carry that nibble, and status line 7 always carries the interrupt output.
- R5: A byte with bits 7:5 = 111 ends the command. The status nibble then reads zero and later data bytes are ignored until a new address byte.
- R6: Offset 10 holds sticky event flags: bit 0 transmit done, bit 1 transmit error, bit 2 receive done. Each is set by its event input and cleared by writing 1 to it.
- R7: The interrupt output is high exactly when the control enable is high and some flag in offset 10 is also set in the mask at offset 11.
- R8: Writing the low half of offset 12 gives a one-cycle transmit pulse for bit 2 and a one-cycle retransmit pulse for bit 3. The low half stores nothing and reads zero.
- R9: In the high half of offset 12, bit 0 drives the transmit enable and bit 1 drives the receive enable. Writing bit 2 there clears every register.
- R10: Latching offset 14 for write from idle rewinds the buffer pointer. Each low nibble is held, and each high nibble stores the byte {high, low} at the pointer and then advances it.
- R11: Latching offset 14 for read from idle rewinds the pointer. Status shows the low or high nibble of the byte at the pointer, and the pointer advances when a high-half buffer read is followed by any new byte.
- R12: Bytes whose bits 7:5 are 001, 011, 100 or 101 change neither the latched address nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_i | input | 8 | Host data lines, sampled every clock |
| irq_en_i | input | 1 | Host control line allowing the interrupt output |
| ev_i | input | 3 | Event strobes: transmit done, transmit error, receive done |
| status_o | output | 5 | Status lines 7:3 (7 = interrupt, 6:3 = read nibble) |
| irq_o | output | 1 | Gated interrupt |
| tx_go_o | output | 1 | One-cycle transmit trigger |
| retx_go_o | output | 1 | One-cycle retransmit trigger |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |

## Verification
The bench goes after the commit rule. It checks that repeated bytes, preview bytes and data bytes that keep bit 4 commit nothing. A design that committed on every data byte would overwrite the low half with the high value during a nibble-mode byte write. It also checks that stray phase codes, and data bytes sent while idle, leave the latched read intact; a design that got this wrong would jump to another register. For the buffer it checks pointer rewinding and stepping across a two-byte burst and a re-read. An off-by-one step would return the second byte first. It also checks that the self-clearing triggers last exactly one cycle and that a soft reset through the command register wipes prior writes.

// File: rtl/nibble_port_pkg.sv
package nibble_port_pkg;
  localparam logic [2:0] PH_DATA = 3'b000;
  localparam logic [2:0] PH_WADR = 3'b010;
  localparam logic [2:0] PH_RADR = 3'b110;
  localparam logic [2:0] PH_END  = 3'b111;

  localparam logic [3:0] OFS_FLAGS = 4'd10;
  localparam logic [3:0] OFS_MASK  = 4'd11;
  localparam logic [3:0] OFS_CMD   = 4'd12;
  localparam logic [3:0] OFS_BUF   = 4'd14;

  typedef enum logic [1:0] {M_IDLE, M_WR, M_RD} mode_e;

  function automatic logic [2:0] phase_of(input logic [7:0] b);
    return b[7:5];
  endfunction

  function automatic logic [3:0] half_of(input logic [7:0] v, input logic hi);
    return hi ? v[7:4] : v[3:0];
  endfunction

  function automatic logic [7:0] merge_half(input logic [7:0] v, input logic hi,
                                            input logic [3:0] n);
    return hi ? {n, v[3:0]} : {v[7:4], n};
  endfunction
endpackage

// File: rtl/nib_decoder.sv
module nib_decoder
  import nibble_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pd_i,
  output logic       cmt_o,
  output logic       cmt_hi_o,
  output logic [3:0] cmt_nib_o,
  output logic [3:0] addr_o,
  output logic       rd_act_o,
  output logic       rd_hi_o,
  output logic       ptr_clr_o,
  output logic       rd_done_o
);
  logic [7:0] prev_q;
  mode_e      mode_q;
  logic [3:0] addr_q;
  logic       hi_q;
  logic       new_byte;
  logic [2:0] ph;

  assign new_byte = (pd_i != prev_q);
  assign ph       = phase_of(pd_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= {PH_END, 5'd0};
      mode_q <= M_IDLE;
      addr_q <= '0;
      hi_q   <= 1'b0;
    end else if (new_byte) begin
      prev_q <= pd_i;
      case (ph)
        PH_END:  mode_q <= M_IDLE;
        PH_WADR: if (mode_q != M_WR) begin
          mode_q <= M_WR;
          addr_q <= pd_i[3:0];
        end
        PH_RADR: begin
          mode_q <= M_RD;
          addr_q <= pd_i[3:0];
          hi_q   <= pd_i[4];
        end
        default: ;
      endcase
    end
  end

  assign cmt_o     = new_byte && (ph == PH_DATA) && (mode_q == M_WR) &&
                     ((phase_of(prev_q) != PH_DATA) || (prev_q[4] != pd_i[4]));
  assign cmt_hi_o  = pd_i[4];
  assign cmt_nib_o = pd_i[3:0];
  assign addr_o    = addr_q;
  assign rd_act_o  = (mode_q == M_RD);
  assign rd_hi_o   = hi_q;
  assign ptr_clr_o = new_byte && (mode_q == M_IDLE) &&
                     ((ph == PH_WADR) || (ph == PH_RADR)) && (pd_i[3:0] == OFS_BUF);
  assign rd_done_o = new_byte && (mode_q == M_RD) && (addr_q == OFS_BUF) && hi_q;
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
  import nibble_port_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NEV  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmt_i,
  input  logic           cmt_hi_i,
  input  logic [3:0]     cmt_nib_i,
  input  logic [3:0]     addr_i,
  input  logic           rd_hi_i,
  input  logic [NEV-1:0] ev_i,
  input  logic           irq_en_i,
  output logic [3:0]     rd_nib_o,
  output logic [NEV-1:0] flags_o,
  output logic           irq_o,
  output logic           tx_go_o,
  output logic           retx_go_o,
  output logic           tx_en_o,
  output logic           rx_en_o
);
  logic [7:0] rf_q [NREG];
  logic       wr_reg;

  assign wr_reg = cmt_i && (addr_i != OFS_BUF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
      tx_go_o   <= 1'b0;
      retx_go_o <= 1'b0;
    end else begin
      tx_go_o   <= 1'b0;
      retx_go_o <= 1'b0;
      if (wr_reg) begin
        if (addr_i == OFS_FLAGS) begin
          if (cmt_hi_i) rf_q[OFS_FLAGS][7:4] <= rf_q[OFS_FLAGS][7:4] & ~cmt_nib_i;
          else          rf_q[OFS_FLAGS][3:0] <= rf_q[OFS_FLAGS][3:0] & ~cmt_nib_i;
        end else if (addr_i == OFS_CMD && !cmt_hi_i) begin
          tx_go_o   <= cmt_nib_i[2];
          retx_go_o <= cmt_nib_i[3];
        end else if (addr_i == OFS_CMD && cmt_nib_i[2]) begin
          for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
          rf_q[addr_i] <= merge_half(rf_q[addr_i], cmt_hi_i, cmt_nib_i);
        end
      end
      for (int e = 0; e < NEV; e++)
        if (ev_i[e]) rf_q[OFS_FLAGS][e] <= 1'b1;
    end
  end

  assign rd_nib_o = half_of(rf_q[addr_i], rd_hi_i);
  assign flags_o  = rf_q[OFS_FLAGS][NEV-1:0];
  assign irq_o    = irq_en_i && |(rf_q[OFS_FLAGS][NEV-1:0] & rf_q[OFS_MASK][NEV-1:0]);
  assign tx_en_o  = rf_q[OFS_CMD][4];
  assign rx_en_o  = rf_q[OFS_CMD][5];
endmodule

// File: rtl/nib_buffer.sv
module nib_buffer
  import nibble_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [3:0]    nib_i,
  input  logic          ptr_clr_i,
  input  logic          rd_done_i,
  input  logic          rd_hi_i,
  output logic [3:0]    rd_nib_o,
  output logic [PW-1:0] ptr_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [3:0]    lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      ptr_q <= '0;
      lo_q  <= '0;
    end else begin
      if (wr_lo_i) lo_q <= nib_i;
      if (wr_hi_i) mem_q[ptr_q] <= {nib_i, lo_q};
      if (ptr_clr_i)                 ptr_q <= '0;
      else if (wr_hi_i || rd_done_i) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign rd_nib_o = half_of(mem_q[ptr_q], rd_hi_i);
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/nibble_port_regs.sv
module nibble_port_regs
  import nibble_port_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int NEV       = 3,
  parameter int BUF_DEPTH = 16,
  localparam int PW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     pd_i,
  input  logic           irq_en_i,
  input  logic [NEV-1:0] ev_i,
  output logic [7:3]     status_o,
  output logic           irq_o,
  output logic           tx_go_o,
  output logic           retx_go_o,
  output logic           tx_en_o,
  output logic           rx_en_o
);
  logic          cmt_w, cmt_hi_w, rd_act_w, rd_hi_w, ptr_clr_w, rd_done_w;
  logic [3:0]    cmt_nib_w, addr_w, rf_nib_w, buf_nib_w;
  logic [NEV-1:0] isr_w;
  logic [PW-1:0] ptr_w;
  logic          to_buf_w, bwr_lo_w, bwr_hi_w;
  logic [3:0]    nib_sel_w;

  nib_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .pd_i(pd_i),
    .cmt_o(cmt_w), .cmt_hi_o(cmt_hi_w), .cmt_nib_o(cmt_nib_w),
    .addr_o(addr_w), .rd_act_o(rd_act_w), .rd_hi_o(rd_hi_w),
    .ptr_clr_o(ptr_clr_w), .rd_done_o(rd_done_w)
  );

  nib_regfile #(.NREG(NREG), .NEV(NEV)) u_rf (
    .clk(clk), .rst_n(rst_n), .cmt_i(cmt_w), .cmt_hi_i(cmt_hi_w),
    .cmt_nib_i(cmt_nib_w), .addr_i(addr_w), .rd_hi_i(rd_hi_w),
    .ev_i(ev_i), .irq_en_i(irq_en_i), .rd_nib_o(rf_nib_w), .flags_o(isr_w),
    .irq_o(irq_o), .tx_go_o(tx_go_o), .retx_go_o(retx_go_o),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o)
  );

  assign to_buf_w = (addr_w == OFS_BUF);
  assign bwr_lo_w = cmt_w && to_buf_w && !cmt_hi_w;
  assign bwr_hi_w = cmt_w && to_buf_w && cmt_hi_w;

  nib_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_lo_i(bwr_lo_w), .wr_hi_i(bwr_hi_w),
    .nib_i(cmt_nib_w), .ptr_clr_i(ptr_clr_w), .rd_done_i(rd_done_w),
    .rd_hi_i(rd_hi_w), .rd_nib_o(buf_nib_w), .ptr_o(ptr_w)
  );

  assign nib_sel_w = !rd_act_w ? 4'h0 : (to_buf_w ? buf_nib_w : rf_nib_w);
  assign status_o  = {irq_o, nib_sel_w};
endmodule

// File: rtl/nibble_port_checker.sv
module nibble_port_checker #(
  parameter int NEV = 3,
  parameter int PW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     pd_i,
  input logic           irq_en_i,
  input logic [NEV-1:0] ev_i,
  input logic [7:3]     status_o,
  input logic           irq_o,
  input logic           tx_go_o,
  input logic           retx_go_o,
  input logic           cmt_w,
  input logic           rd_act_w,
  input logic           bwr_hi_w,
  input logic [PW-1:0]  ptr_w,
  input logic [NEV-1:0] isr_w
);
  p_no_repeat_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_w |-> (pd_i != $past(pd_i)));
  p_idle_nibble_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act_w |-> (status_o[6:3] == 4'h0));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i[0] |=> isr_w[0]);
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
  p_line7_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] == irq_o);
  p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go_o |=> !tx_go_o);
  p_retx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retx_go_o |=> !retx_go_o);
  p_ptr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bwr_hi_w |=> (ptr_w == PW'($past(ptr_w) + 1'b1)));
endmodule

bind nibble_port_regs nibble_port_checker #(.NEV(NEV), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .irq_en_i(irq_en_i), .ev_i(ev_i),
  .status_o(status_o), .irq_o(irq_o), .tx_go_o(tx_go_o), .retx_go_o(retx_go_o),
  .cmt_w(cmt_w), .rd_act_w(rd_act_w), .bwr_hi_w(bwr_hi_w), .ptr_w(ptr_w),
  .isr_w(isr_w)
);

// File: tb/test_nibble_port_regs.sv
module test_nibble_port_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pd = 8'hE0;
  logic       irq_en = 1'b0;
  logic [2:0] ev = 3'b000;
  logic [7:3] status;
  logic       irq, tx_go, retx_go, tx_en, rx_en;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  nibble_port_regs i_nibble_port_regs (
    .clk(clk), .rst_n(rst_n), .pd_i(pd), .irq_en_i(irq_en), .ev_i(ev),
    .status_o(status), .irq_o(irq), .tx_go_o(tx_go), .retx_go_o(retx_go),
    .tx_en_o(tx_en), .rx_en_o(rx_en)
  );

  // {byte, check flag, expected {line7, nibble}}
  localparam int NV = 23;
  localparam logic [13:0] VEC [NV] = '{
    {8'h40, 1'b0, 5'h00}, {8'h43, 1'b0, 5'h00}, {8'h03, 1'b0, 5'h00},
    {8'h09, 1'b0, 5'h00}, {8'h19, 1'b0, 5'h00}, {8'h19, 1'b0, 5'h00},
    {8'hE0, 1'b1, 5'h00}, {8'hC0, 1'b1, 5'h03}, {8'hD0, 1'b1, 5'h09},
    {8'hE0, 1'b1, 5'h00}, {8'h07, 1'b1, 5'h00}, {8'hC0, 1'b1, 5'h03},
    {8'hE0, 1'b0, 5'h00}, {8'h45, 1'b0, 5'h00}, {8'h0F, 1'b0, 5'h00},
    {8'hE0, 1'b0, 5'h00}, {8'hC5, 1'b1, 5'h0F}, {8'h2F, 1'b1, 5'h0F},
    {8'hBF, 1'b1, 5'h0F}, {8'h7A, 1'b1, 5'h0F}, {8'h9A, 1'b1, 5'h0F},
    {8'hD5, 1'b1, 5'h00}, {8'hE0, 1'b1, 5'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    pd = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 status", status, 5'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 enables", {tx_en, rx_en, tx_go, retx_go}, 4'h0);

    // R2 R3 R4 R5 R12: vector walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][13:6]);
      if (VEC[i][5]) check($sformatf("R2/R4/R5/R12 vec%0d", i), status, VEC[i][4:0]);
    end

    // R3: data byte keeping bit 4 commits nothing
    send(8'h46); send(8'h01); send(8'h02); send(8'h02); send(8'hE0);
    send(8'hC6);
    check("R3 no second commit", status, 5'h01);
    send(8'hE0);

    // R6 R7: flags and interrupt gating
    @(negedge clk); ev = 3'b001; @(negedge clk); ev = 3'b000;
    irq_en = 1'b1;
    @(negedge clk);
    check("R7 masked off", irq, 1'b0);
    send(8'h4B); send(8'h05); send(8'hE0);
    check("R7 mask hit", irq, 1'b1);
    send(8'hCA);
    check("R6 flag read, R4 line7", status, 5'h11);
    send(8'hE0);
    irq_en = 1'b0;
    @(negedge clk);
    check("R7 enable low", irq, 1'b0);
    irq_en = 1'b1;
    send(8'h4A); send(8'h01); send(8'hE0);
    check("R6 write-one clear", irq, 1'b0);
    send(8'hCA);
    check("R6 cleared value", status, 5'h00);
    send(8'hE0);
    irq_en = 1'b0;

    // R8: one-cycle triggers
    send(8'h4C); send(8'h04);
    check("R8 tx pulse", {tx_go, retx_go}, 2'b10);
    @(negedge clk);
    check("R8 tx pulse ends", tx_go, 1'b0);
    send(8'hE0); send(8'h4C); send(8'h08);
    check("R8 retx pulse", {tx_go, retx_go}, 2'b01);
    send(8'hE0); send(8'hCC);
    check("R8 low half reads zero", status, 5'h00);
    send(8'hE0);

    // R9: enables and soft reset
    send(8'h4C); send(8'h13);
    check("R9 enables", {tx_en, rx_en}, 2'b11);
    send(8'h00); send(8'h14); send(8'hE0);
    check("R9 soft reset enables", {tx_en, rx_en}, 2'b00);
    send(8'hD0);
    check("R9 soft reset reg0", status, 5'h00);
    send(8'hE0);

    // R10 R11: buffer burst
    send(8'h4E); send(8'h05); send(8'h1A); send(8'h03); send(8'h1C); send(8'hE0);
    send(8'hCE);
    check("R11 byte0 low", status, 5'h05);
    send(8'hDE);
    check("R10 byte0 high", status, 5'h0A);
    send(8'hCE);
    check("R11 byte1 low", status, 5'h03);
    send(8'hDE);
    check("R10 byte1 high", status, 5'h0C);
    send(8'hE0);
    send(8'hCE);
    check("R11 rewind", status, 5'h05);
    send(8'hE0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule